// File: doc/BRIEF.md
# Change-Interrupt GPIO Port

This block is an eight-pin general-purpose I/O port core for a register-mapped peripheral. Software-facing logic writes one of four byte registers through a write strobe with a two-bit index, and reads any of them through a read index. The port drives a per-pin output enable and output value toward the pad ring. It also samples the pad levels through a two-flop synchronizer, so that they can be read back and watched for change.

Each pin's direction comes from its own configuration bit. A read of the input register returns the synchronized pin levels, each bit optionally inverted by the polarity mask. A read strobe on the input register also records a snapshot of the synchronized levels. An active-low interrupt reports that an input-configured pin no longer matches that snapshot. The interrupt falls away by itself if the pin returns to its snapshot level, and it also clears when the input register is read. The interrupt is a registered output.

Top module: `gpx_port`

## Requirements
- R1: After reset the output register reads 0xFF, polarity reads 0x00, direction reads 0xFF, pin_oe is 0x00, pin_out is 0x00 and irq_n is 1; the synchronizer and the snapshot both reset to 0xFF.
- R2: Index encoding: 0 input, 1 output, 2 polarity, 3 direction. A write strobe on index 1, 2 or 3 stores wr_data in that register, and rd_data returns it when rd_idx selects that index.
- R3: With rd_idx = 0, rd_data equals the pin levels XOR the polarity register, for every pin whatever its direction; pin_in reaches rd_data after two clock edges.
- R4: A write strobe on index 0 changes no register and no output.
- R5: Reading index 1 returns the stored output register, not the pin levels.
- R6: A direction bit of 1 makes the pin an input, with pin_oe low and pin_out low. A direction bit of 0 makes pin_oe high and pin_out equal to the matching output register bit.
- R7: irq_n goes low when an input-configured pin differs from the snapshot. A pin change takes three clock edges to reach irq_n: it is still high after two edges and low after the third.
- R8: irq_n returns high once the pin comes back to its snapshot level, with no read needed.
- R9: A read strobe with rd_idx = 0 loads the snapshot from the synchronized pins; irq_n is high in the cycle after that strobe.
- R10: Pins configured as outputs never pull irq_n low, whatever their level.
- R11: Turning an output pin into an input while its level differs from the snapshot drives irq_n low.
- R12: A read strobe on indices 1 to 3 neither clears the interrupt nor updates the snapshot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 2 | Register index for the write |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe; on index 0 it loads the snapshot |
| rd_idx | input | 2 | Register index for the read |
| rd_data | output | 8 | Read data for rd_idx (combinational) |
| pin_in | input | 8 | Pad levels, asynchronous |
| pin_oe | output | 8 | Per-pin output driver enable |
| pin_out | output | 8 | Per-pin driven value |
| irq_n | output | 1 | Registered active-low change interrupt |

## Verification
Directed steps first test single patterns. A pin move on an input-direction pin and its return test the interrupt's self-release against clearing by a read. The same move on an output-direction pin shows that the direction mask is honoured. A switch from output to input over a mismatched level covers the case where a direction change alone must raise the interrupt. Constrained random register writes, pin patterns and reads of every index then run against a bench-side model. Across mixed polarity and direction masks, these separate inverting the pin from inverting the snapshot, and a read of the input register from reads of other indices.

// File: rtl/gpx_pkg.sv
package gpx_pkg;

    localparam int unsigned GPX_WIDTH = 8;
    localparam int unsigned GPX_IDX_W = 2;
    localparam int unsigned GPX_SYNC_STAGES = 2;

    typedef enum logic [GPX_IDX_W-1:0] {
        REG_IN  = 2'd0,
        REG_OUT = 2'd1,
        REG_POL = 2'd2,
        REG_DIR = 2'd3
    } gpx_reg_e;

    typedef struct packed {
        logic     en;
        gpx_reg_e idx;
    } gpx_cmd_t;

    function automatic gpx_cmd_t make_cmd(input logic en, input logic [GPX_IDX_W-1:0] idx);
        gpx_cmd_t c;
        c.en  = en;
        c.idx = gpx_reg_e'(idx);
        return c;
    endfunction

    function automatic logic hits(input gpx_cmd_t c, input gpx_reg_e r);
        return c.en && (c.idx == r);
    endfunction

endpackage

// File: rtl/gpx_sync.sv
module gpx_sync #(
    parameter int unsigned W      = gpx_pkg::GPX_WIDTH,
    parameter int unsigned STAGES = gpx_pkg::GPX_SYNC_STAGES
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stage[0] <= '1;
        else     stage[0] <= d;
    end

    for (genvar s = 1; s < int'(STAGES); s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stage[s] <= '1;
            else     stage[s] <= stage[s-1];
        end
    end

    assign q = stage[STAGES-1];
endmodule

// File: rtl/gpx_regs.sv
module gpx_regs
    import gpx_pkg::*;
#(
    parameter int unsigned W = GPX_WIDTH
) (
    input  logic         clk,
    input  logic         rst,
    input  gpx_cmd_t     wr_cmd,
    input  logic [W-1:0] wr_data,
    input  gpx_reg_e     rd_sel,
    input  logic [W-1:0] pins_sync,
    output logic [W-1:0] dir_q,
    output logic [W-1:0] rd_data,
    output logic [W-1:0] pin_oe,
    output logic [W-1:0] pin_out
);
    logic [W-1:0] out_q;
    logic [W-1:0] pol_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '1;
            pol_q <= '0;
            dir_q <= '1;
        end else begin
            if (hits(wr_cmd, REG_OUT)) out_q <= wr_data;
            if (hits(wr_cmd, REG_POL)) pol_q <= wr_data;
            if (hits(wr_cmd, REG_DIR)) dir_q <= wr_data;
        end
    end

    always_comb begin
        unique case (rd_sel)
            REG_IN:  rd_data = pins_sync ^ pol_q;
            REG_OUT: rd_data = out_q;
            REG_POL: rd_data = pol_q;
            REG_DIR: rd_data = dir_q;
            default: rd_data = '0;
        endcase
    end

    for (genvar b = 0; b < int'(W); b++) begin : g_pin
        assign pin_oe[b]  = ~dir_q[b];
        assign pin_out[b] = dir_q[b] ? 1'b0 : out_q[b];
    end

    assert_idx0_ignored_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_cmd.en && wr_cmd.idx == REG_IN) |=> ($stable(out_q) && $stable(pol_q) && $stable(dir_q)));

    assert_out_write_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_cmd.en && wr_cmd.idx == REG_OUT) |=> (out_q == $past(wr_data)));

    assert_dir_drives_oe_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_cmd.en && wr_cmd.idx == REG_DIR) |=> (pin_oe == ~$past(wr_data)));
endmodule

// File: rtl/gpx_irq.sv
module gpx_irq #(
    parameter int unsigned W = gpx_pkg::GPX_WIDTH
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         snap_take,
    input  logic [W-1:0] pins_sync,
    input  logic [W-1:0] dir_q,
    output logic         irq_n
);
    logic [W-1:0] snap_q;
    logic [W-1:0] diff;
    logic         irq_n_q;

    always_ff @(posedge clk) begin
        if (rst)            snap_q <= '1;
        else if (snap_take) snap_q <= pins_sync;
    end

    for (genvar b = 0; b < int'(W); b++) begin : g_cmp
        assign diff[b] = dir_q[b] & (pins_sync[b] ^ snap_q[b]);
    end

    always_ff @(posedge clk) begin
        if (rst)            irq_n_q <= 1'b1;
        else if (snap_take) irq_n_q <= 1'b1;
        else                irq_n_q <= ~(|diff);
    end

    assign irq_n = irq_n_q;

    assert_read_clears_R9: assert property (@(posedge clk) disable iff (rst)
        snap_take |=> irq_n);

    assert_snap_load_R9: assert property (@(posedge clk) disable iff (rst)
        snap_take |=> (snap_q == $past(pins_sync)));

    assert_outputs_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        (dir_q == '0) |=> irq_n);

    assert_snap_hold_R12: assert property (@(posedge clk) disable iff (rst)
        !snap_take |=> $stable(snap_q));
endmodule

// File: rtl/gpx_port.sv
module gpx_port
    import gpx_pkg::*;
#(
    parameter int unsigned W = GPX_WIDTH
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [GPX_IDX_W-1:0] wr_idx,
    input  logic [W-1:0]         wr_data,
    input  logic                 rd_en,
    input  logic [GPX_IDX_W-1:0] rd_idx,
    output logic [W-1:0]         rd_data,
    input  logic [W-1:0]         pin_in,
    output logic [W-1:0]         pin_oe,
    output logic [W-1:0]         pin_out,
    output logic                 irq_n
);
    gpx_cmd_t     wr_cmd;
    gpx_cmd_t     rd_cmd;
    logic [W-1:0] pins_sync;
    logic [W-1:0] dir_q;

    assign wr_cmd = make_cmd(wr_en, wr_idx);
    assign rd_cmd = make_cmd(rd_en, rd_idx);

    gpx_sync #(.W(W), .STAGES(GPX_SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_in),
        .q   (pins_sync)
    );

    gpx_regs #(.W(W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_cmd    (wr_cmd),
        .wr_data   (wr_data),
        .rd_sel    (rd_cmd.idx),
        .pins_sync (pins_sync),
        .dir_q     (dir_q),
        .rd_data   (rd_data),
        .pin_oe    (pin_oe),
        .pin_out   (pin_out)
    );

    gpx_irq #(.W(W)) u_irq (
        .clk       (clk),
        .rst       (rst),
        .snap_take (hits(rd_cmd, REG_IN)),
        .pins_sync (pins_sync),
        .dir_q     (dir_q),
        .irq_n     (irq_n)
    );

    assert_oe_out_R6: assert property (@(posedge clk) disable iff (rst)
        ((pin_out & ~pin_oe) == '0));
endmodule

// File: tb/sim_gpx_port.sv
`timescale 1ns/1ps
module sim_gpx_port;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_idx = 2'd0;
    logic [7:0] wr_data = 8'h00;
    logic       rd_en = 1'b0;
    logic [1:0] rd_idx = 2'd0;
    logic [7:0] rd_data;
    logic [7:0] pin_in = 8'hFF;
    logic [7:0] pin_oe;
    logic [7:0] pin_out;
    logic       irq_n;

    int checks = 0;
    int failures = 0;
    logic [7:0] m_out, m_pol, m_dir, m_snap, m_pins;

    always #2.5 clk = ~clk;

    gpx_port u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .rd_en(rd_en), .rd_idx(rd_idx), .rd_data(rd_data), .pin_in(pin_in),
        .pin_oe(pin_oe), .pin_out(pin_out), .irq_n(irq_n)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    function automatic logic exp_irq_n();
        return ~(|((m_pins ^ m_snap) & m_dir));
    endfunction

    task automatic settle();
        repeat (4) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic peek(input logic [1:0] idx, output logic [7:0] v);
        rd_idx = idx;
        #1;
        v = rd_data;
    endtask

    task automatic check_all(input string req);
        logic [7:0] v;
        peek(2'd0, v); check({req, " R3 input"}, v, m_pins ^ m_pol);
        peek(2'd1, v); check({req, " R5 output"}, v, m_out);
        peek(2'd2, v); check({req, " R2 polarity"}, v, m_pol);
        peek(2'd3, v); check({req, " R2 direction"}, v, m_dir);
        check({req, " R6 oe"}, pin_oe, ~m_dir);
        check({req, " R6 out"}, pin_out, m_out & ~m_dir);
        check({req, " R7 irq"}, {7'd0, irq_n}, {7'd0, exp_irq_n()});
    endtask

    task automatic do_write(input logic [1:0] idx, input logic [7:0] d);
        wr_en = 1'b1; wr_idx = idx; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        case (idx)
            2'd1: m_out = d;
            2'd2: m_pol = d;
            2'd3: m_dir = d;
            default: ;
        endcase
    endtask

    task automatic do_read(input logic [1:0] idx);
        rd_en = 1'b1; rd_idx = idx;
        @(posedge clk);
        @(negedge clk);
        rd_en = 1'b0;
        if (idx == 2'd0) begin
            m_snap = m_pins;
            check("R9 irq released after input read", {7'd0, irq_n}, 8'd1);
        end
    endtask

    task automatic set_pins(input logic [7:0] p);
        pin_in = p;
        m_pins = p;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [7:0] v;
        void'($urandom(32'd20240611));
        m_out = 8'hFF; m_pol = 8'h00; m_dir = 8'hFF; m_snap = 8'hFF; m_pins = 8'hFF;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check_all("R1 reset");
        check("R1 irq_n", {7'd0, irq_n}, 8'd1);

        do_write(2'd1, 8'hA5);
        do_write(2'd2, 8'h0F);
        do_write(2'd3, 8'hF0);
        settle();
        check_all("R2 readback");
        check("R6 pin_out", pin_out, 8'h05);
        peek(2'd1, v); check("R5 output not pins", v, 8'hA5);

        do_write(2'd0, 8'h00);
        settle();
        check_all("R4 index0 write ignored");

        // R7 latency: pin change seen on irq_n after the third edge
        set_pins(8'h3C);
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R7 irq still high after two edges", {7'd0, irq_n}, 8'd1);
        @(posedge clk);
        @(negedge clk);
        check("R7 irq low after three edges", {7'd0, irq_n}, 8'd0);
        peek(2'd0, v); check("R3 inverted input", v, 8'h33);

        set_pins(8'hFF);
        settle();
        check("R8 self release", {7'd0, irq_n}, 8'd1);

        set_pins(8'h3C);
        settle();
        check("R9 irq before read", {7'd0, irq_n}, 8'd0);
        do_read(2'd0);
        settle();
        check_all("R9 after input read");

        set_pins(8'hFF);
        settle();
        do_read(2'd1);
        do_read(2'd3);
        settle();
        check("R12 other reads keep irq", {7'd0, irq_n}, 8'd0);
        check_all("R12 snapshot kept");

        do_write(2'd3, 8'h00);
        settle();
        check("R10 outputs masked", {7'd0, irq_n}, 8'd1);
        set_pins(8'h55);
        settle();
        check("R10 output pin moves", {7'd0, irq_n}, 8'd1);

        do_write(2'd3, 8'hFF);
        settle();
        check("R11 output to input mismatch", {7'd0, irq_n}, 8'd0);
        check_all("R11 state");
        do_read(2'd0);
        settle();

        for (int i = 0; i < 300; i++) begin
            int op;
            op = $urandom_range(0, 9);
            if (op < 4)      do_write(2'($urandom_range(0, 3)), 8'($urandom));
            else if (op < 7) set_pins(8'($urandom));
            else if (op < 9) do_read(2'($urandom_range(0, 3)));
            else             do_read(2'd0);
            settle();
            check_all("random");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule